// File: doc/BRIEF.md
# Virtual Cache Tag and Valid Controller

This block holds the tag and the per-line valid state of a direct-mapped external cache. The cache is indexed and tagged by the virtual address, and one array serves both instructions and data. Every line keeps two valid bits, one for user mode and one for supervisor mode. A lookup answers hit or miss in the same cycle as the access. Address translation can therefore run alongside it, and the page cache-inhibit flag from translation is applied in that same cycle. A miss on a page that may be cached raises a fill request. When the refill is done, the fill port installs the tag and sets the valid bit of the fill's mode.

Flushes happen as side effects of register writes. A control write that changes the cache-enable bit (bit 2 of the control data) invalidates every line in both modes. A write to the user segment-table base drops all user valid bits. A write to the supervisor base drops all supervisor valid bits. The data array and the refill path are outside this block.

Top module: `vc_tag_ctrl`

## Requirements
- R1: After reset the cache is disabled and holds no valid line, so every access reports hit=0 and fill_req=0.
- R2: An access hits in the same cycle when all of these are true: acc_valid is set, the cache is enabled, acc_inhibit is low, the stored tag of line va[13:4] equals va[31:14], and that line's valid bit for acc_sup (0 user, 1 supervisor) is set.
- R3: A fill that is accepted sets only the valid bit of fill_sup's mode. If the stored tag of that line is unchanged, the other mode's bit keeps its value. The new state is visible from the next cycle.
- R4: fill_req is 1 exactly for a valid, enabled, non-inhibited access that misses. hit and fill_req are never both 1.
- R5: An access with acc_inhibit=1 neither hits nor requests a fill.
- R6: While the cache is disabled, every access misses without a fill request, and fill_we is ignored.
- R7: A control write whose bit 2 differs from the current enable state loads the new state and clears both valid bits of every line. A control write with an equal bit 2 changes nothing.
- R8: A ubase_wr pulse clears every user valid bit and leaves the supervisor bits unchanged.
- R9: An sbase_wr pulse clears every supervisor valid bit and leaves the user bits unchanged.
- R10: A flush in the same cycle as a fill wins: the filled line is invalid in each mode that the flush covers.
- R11: A fill whose tag differs from the line's stored tag also clears the other mode's valid bit of that line. The four offset bits va[3:0] never affect a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_va | input | 32 | Virtual address of the access |
| acc_sup | input | 1 | Access mode: 1 supervisor, 0 user |
| acc_inhibit | input | 1 | Cache-inhibit flag of the page, from translation |
| hit | output | 1 | Lookup hit, same cycle |
| fill_req | output | 1 | Cacheable miss, refill requested |
| fill_we | input | 1 | Refill complete: install line |
| fill_va | input | 32 | Virtual address of the refilled line |
| fill_sup | input | 1 | Mode of the refill |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data, bit 2 = cache enable |
| ubase_wr | input | 1 | User segment-table base write strobe |
| sbase_wr | input | 1 | Supervisor segment-table base write strobe |

## Verification
Stale valid state shows up as a hit where a miss is expected, or as a hit on the wrong mode. Lost state shows up as a spurious fill_req. Both appear on the first access to the affected line after the fill or flush edge that caused them. The bench keeps a reference model and compares hit and fill_req against it every cycle. Because those outputs are combinational, a corrupted valid bit or tag is exposed one cycle after the edge that corrupted it, provided the stimulus touches that line. Random addresses are drawn from a few indices and tags, so conflicts, mode crossings and flushes hit live lines often.

// File: rtl/vc_pkg.sv
package vc_pkg;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } mode_e;

    typedef struct packed {
        logic all;
        logic usr;
        logic sup;
    } flush_t;

    localparam int CTL_W      = 16;
    localparam int CTL_EN_BIT = 2;

    function automatic logic mode_valid(mode_e m, logic vu, logic vs);
        return (m == MODE_SUPER) ? vs : vu;
    endfunction

endpackage

// File: rtl/vc_flush_ctrl.sv
module vc_flush_ctrl
    import vc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ubase_wr,
    input  logic             sbase_wr,
    output logic             en,
    output flush_t           flush
);

    logic en_new;
    logic unused_ctl;

    assign en_new     = ctl_wdata[CTL_EN_BIT];
    assign unused_ctl = ^ctl_wdata;

    always_comb begin
        flush.all = ctl_wr && (en_new != en);
        flush.usr = ubase_wr;
        flush.sup = sbase_wr;
    end

    always_ff @(posedge clk) begin
        if (rst)         en <= 1'b0;
        else if (ctl_wr) en <= en_new;
    end

    // R7: a full flush always coincides with an enable change
    p_toggle_flips_en_r7: assert property (@(posedge clk) disable iff (rst)
        flush.all |=> (en != $past(en)));

    // R7: an equal-value control write leaves the enable state alone
    p_same_write_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !flush.all) |=> $stable(en));

endmodule

// File: rtl/vc_tag_store.sv
module vc_tag_store #(
    parameter  int LINES = 1024,
    parameter  int TAG_W = 18,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [TAG_W-1:0] old_tag
);

    logic [TAG_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_tag;
    end

    assign rd_tag  = mem[rd_idx];
    assign old_tag = mem[wr_idx];

endmodule

// File: rtl/vc_valid_store.sv
module vc_valid_store
    import vc_pkg::*;
#(
    parameter  int LINES = 1024,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_usr,
    output logic             rd_sup,
    input  logic             set_we,
    input  logic [IDX_W-1:0] set_idx,
    input  mode_e            set_mode,
    input  logic             clr_other,
    input  flush_t           flush
);

    logic [LINES-1:0] vu, vs, vu_n, vs_n;

    always_comb begin
        vu_n = vu;
        vs_n = vs;
        if (set_we) begin
            if (set_mode == MODE_SUPER) begin
                vs_n[set_idx] = 1'b1;
                if (clr_other) vu_n[set_idx] = 1'b0;
            end else begin
                vu_n[set_idx] = 1'b1;
                if (clr_other) vs_n[set_idx] = 1'b0;
            end
        end
        if (flush.all || flush.usr) vu_n = '0;
        if (flush.all || flush.sup) vs_n = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vu <= '0;
            vs <= '0;
        end else begin
            vu <= vu_n;
            vs <= vs_n;
        end
    end

    assign rd_usr = vu[rd_idx];
    assign rd_sup = vs[rd_idx];

    p_full_flush_r7: assert property (@(posedge clk) disable iff (rst)
        flush.all |=> (vu == '0 && vs == '0));

    p_user_flush_r8: assert property (@(posedge clk) disable iff (rst)
        flush.usr |=> (vu == '0));

    p_user_flush_keeps_sup_r8: assert property (@(posedge clk) disable iff (rst)
        (flush.usr && !flush.all && !flush.sup && !set_we) |=> $stable(vs));

    p_sup_flush_r9: assert property (@(posedge clk) disable iff (rst)
        flush.sup |=> (vs == '0));

    // R3: fill without flush marks its own mode valid
    p_fill_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (set_we && flush == '0) |=>
        ($past(set_mode) == MODE_SUPER ? vs[$past(set_idx)] : vu[$past(set_idx)]));

    // R3: fill with matching tag leaves the other mode's bit alone
    p_fill_keeps_other_r3: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_other && flush == '0) |=>
        ($past(set_mode) == MODE_SUPER
            ? (vu[$past(set_idx)] == $past(vu[set_idx]))
            : (vs[$past(set_idx)] == $past(vs[set_idx]))));

endmodule

// File: rtl/vc_tag_ctrl.sv
module vc_tag_ctrl
    import vc_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int CACHE_BYTES = 16384,
    parameter int LINE_BYTES  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [VA_W-1:0]  acc_va,
    input  logic             acc_sup,
    input  logic             acc_inhibit,
    output logic             hit,
    output logic             fill_req,
    input  logic             fill_we,
    input  logic [VA_W-1:0]  fill_va,
    input  logic             fill_sup,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ubase_wr,
    input  logic             sbase_wr
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int LINES = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = VA_W - OFF_W - IDX_W;

    logic [IDX_W-1:0] acc_idx, fill_idx;
    logic [TAG_W-1:0] acc_tag, fill_tag, rd_tag, old_tag;
    logic             en, fill_ok, rd_usr, rd_sup, line_ok, lookup;
    mode_e            acc_mode, fill_mode;
    flush_t           flush;
    logic             unused_off;

    assign acc_idx    = acc_va[OFF_W +: IDX_W];
    assign acc_tag    = acc_va[VA_W-1 -: TAG_W];
    assign fill_idx   = fill_va[OFF_W +: IDX_W];
    assign fill_tag   = fill_va[VA_W-1 -: TAG_W];
    assign acc_mode   = mode_e'(acc_sup);
    assign fill_mode  = mode_e'(fill_sup);
    assign unused_off = ^{acc_va[OFF_W-1:0], fill_va[OFF_W-1:0]};

    vc_flush_ctrl u_flush (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_wdata(ctl_wdata),
        .ubase_wr (ubase_wr),
        .sbase_wr (sbase_wr),
        .en       (en),
        .flush    (flush)
    );

    assign fill_ok = fill_we && en;

    vc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk    (clk),
        .rd_idx (acc_idx),
        .rd_tag (rd_tag),
        .we     (fill_ok),
        .wr_idx (fill_idx),
        .wr_tag (fill_tag),
        .old_tag(old_tag)
    );

    vc_valid_store #(.LINES(LINES)) u_valid (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (acc_idx),
        .rd_usr   (rd_usr),
        .rd_sup   (rd_sup),
        .set_we   (fill_ok),
        .set_idx  (fill_idx),
        .set_mode (fill_mode),
        .clr_other(old_tag != fill_tag),
        .flush    (flush)
    );

    assign line_ok  = mode_valid(acc_mode, rd_usr, rd_sup);
    assign lookup   = acc_valid && en && !acc_inhibit;
    assign hit      = lookup && (rd_tag == acc_tag) && line_ok;
    assign fill_req = lookup && !hit;

    p_hit_or_fill_r4: assert property (@(posedge clk) disable iff (rst)
        !(hit && fill_req));

    p_inhibit_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        acc_inhibit |-> (!hit && !fill_req));

    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!hit && !fill_req));

endmodule

// File: tb/tb_vc_tag_ctrl.sv
module tb_vc_tag_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid, acc_sup, acc_inhibit;
    logic [31:0] acc_va, fill_va;
    logic        fill_we, fill_sup, ctl_wr, ubase_wr, sbase_wr;
    logic [15:0] ctl_wdata;
    logic        hit, fill_req;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    logic [17:0] mtag [1024];
    bit          mvu  [1024];
    bit          mvs  [1024];
    bit          men;

    always #5 clk = ~clk;

    vc_tag_ctrl dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_va(acc_va), .acc_sup(acc_sup),
        .acc_inhibit(acc_inhibit), .hit(hit), .fill_req(fill_req),
        .fill_we(fill_we), .fill_va(fill_va), .fill_sup(fill_sup),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ubase_wr(ubase_wr), .sbase_wr(sbase_wr)
    );

    function automatic bit exp_hit();
        int i = int'(acc_va[13:4]);
        bit v = acc_sup ? mvs[i] : mvu[i];
        return acc_valid && men && !acc_inhibit && (mtag[i] == acc_va[31:14]) && v;
    endfunction

    function automatic bit exp_fill();
        return acc_valid && men && !acc_inhibit && !exp_hit();
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin
            mvu[i] = 0; mvs[i] = 0; mtag[i] = '0;
        end
        men = 0;
    endtask

    task automatic model_edge();
        int fi = int'(fill_va[13:4]);
        if (fill_we && men) begin
            if (mtag[fi] != fill_va[31:14]) begin
                if (fill_sup) mvu[fi] = 0; else mvs[fi] = 0;
            end
            mtag[fi] = fill_va[31:14];
            if (fill_sup) mvs[fi] = 1; else mvu[fi] = 1;
        end
        if (ctl_wr && (ctl_wdata[2] != men)) begin
            for (int i = 0; i < 1024; i++) begin mvu[i] = 0; mvs[i] = 0; end
            men = ctl_wdata[2];
        end
        if (ubase_wr) for (int i = 0; i < 1024; i++) mvu[i] = 0;
        if (sbase_wr) for (int i = 0; i < 1024; i++) mvs[i] = 0;
    endtask

    task automatic idle();
        acc_valid = 0; acc_va = '0; acc_sup = 0; acc_inhibit = 0;
        fill_we = 0; fill_va = '0; fill_sup = 0;
        ctl_wr = 0; ctl_wdata = '0; ubase_wr = 0; sbase_wr = 0;
    endtask

    // inputs are set at the falling edge; outputs compared 2 ns later
    task automatic cyc(string lbl);
        bit eh, ef;
        #2;
        eh = exp_hit();
        ef = exp_fill();
        total++;
        if (hit !== eh || fill_req !== ef) begin
            bad++;
            $display("FAIL %s: va=%h sup=%0b hit=%b fill_req=%b expected hit=%b fill_req=%b",
                     lbl, acc_va, acc_sup, hit, fill_req, eh, ef);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        idle();
    endtask

    task automatic look(logic [31:0] va, bit sup, bit inh, string lbl);
        acc_valid = 1; acc_va = va; acc_sup = sup; acc_inhibit = inh;
        cyc(lbl);
    endtask

    task automatic fill(logic [31:0] va, bit sup);
        fill_we = 1; fill_va = va; fill_sup = sup;
        cyc("fill");
    endtask

    task automatic ctl(bit e);
        ctl_wr = 1; ctl_wdata = 16'(e) << 2;
        cyc("ctl");
    endtask

    task automatic expect_bits(bit eh, bit ef, string lbl);
        total++;
        if (exp_hit() != eh || exp_fill() != ef) begin
            bad++;
            $display("FAIL %s model: hit=%b fill=%b expected %b %b", lbl, exp_hit(), exp_fill(), eh, ef);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            bad++;
            $display("FAIL watchdog: cycles=%0d expected < 200000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [31:0] A  = 32'h0001_4120;
    localparam logic [31:0] B  = 32'h0003_8120;

    initial begin
        idle();
        rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state, disabled
        look(A, 0, 0, "R1 reset miss");
        look(A, 1, 0, "R1 reset miss sup");

        // R6: disabled fill ignored
        fill(A, 0);
        ctl(1);
        acc_valid = 1; acc_va = A; acc_sup = 0;
        expect_bits(0, 1, "R6 no allocation while off");
        cyc("R6 fill ignored while disabled");

        // R4 / R2 / R3 / R11
        look(A, 0, 0, "R4 miss requests fill");
        fill(A, 0);
        look(A, 0, 0, "R2 user hit");
        look(A | 32'hF, 0, 0, "R11 offset ignored");
        look(A, 1, 0, "R3 sup still invalid");
        fill(A, 1);
        look(A, 1, 0, "R3 sup hit");
        look(A, 0, 0, "R3 user kept");
        fill(B, 0);
        acc_valid = 1; acc_va = A; acc_sup = 1;
        expect_bits(0, 1, "R11 conflict clears other mode");
        cyc("R11 conflict clears other mode");
        look(B, 0, 0, "R2 new tag hit");
        look(B, 0, 1, "R5 inhibit no hit no fill");

        // R8 / R9
        fill(B, 1);
        ubase_wr = 1; cyc("R8 flush strobe");
        look(B, 0, 0, "R8 user flushed");
        look(B, 1, 0, "R8 sup kept");
        fill(B, 0);
        sbase_wr = 1; cyc("R9 flush strobe");
        look(B, 1, 0, "R9 sup flushed");
        look(B, 0, 0, "R9 user kept");

        // R7
        ctl(1);
        look(B, 0, 0, "R7 same write no flush");
        ctl(0);
        look(B, 0, 0, "R6 disabled miss");
        ctl(1);
        look(B, 0, 0, "R7 toggle flushed");

        // R10
        fill_we = 1; fill_va = A; fill_sup = 0; ubase_wr = 1;
        cyc("R10 fill+flush");
        acc_valid = 1; acc_va = A; acc_sup = 0;
        expect_bits(0, 1, "R10 flush wins");
        cyc("R10 flush wins");

        // random phase
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom);
            acc_valid   = ($urandom % 8) != 0;
            acc_va      = {14'd0, 4'($urandom % 4), 10'($urandom % 8), 4'($urandom)};
            acc_sup     = 1'($urandom);
            acc_inhibit = ($urandom % 7) == 0;
            fill_we     = ($urandom % 3) == 0;
            fill_va     = {14'd0, 4'($urandom % 4), 10'($urandom % 8), 4'($urandom)};
            fill_sup    = 1'($urandom);
            ctl_wr      = (r % 50) == 0;
            ctl_wdata   = (($urandom % 4) != 0) ? 16'h0004 : 16'h0000;
            ubase_wr    = (r % 61) == 1;
            sbase_wr    = (r % 67) == 2;
            cyc("R2 random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule